// File: doc/BRIEF.md
# Coast Window Generator

This block drives the coast control of a line-locking PLL around the vertical blanking interval. Around vertical sync, the horizontal sync stream carries equalization pulses at twice the line rate, and these would pull the PLL off frequency. The block raises a coast flag over that stretch. The flag rises a programmable number of lines before vertical sync starts. It falls a programmable number of lines after vertical sync ends. Both amounts are counted in whole horizontal sync periods.

The start of vertical sync cannot be seen in advance, so the block counts horizontal sync rising edges between consecutive vertical sync leading edges and keeps that count as the frame length in lines. In each new frame, the early part of the window opens when the running line count comes within the pre-coast amount of the stored length. Until two vertical sync leading edges have been seen, the frame length is unknown, and only vertical sync plus its trailing extension drive the flag. The hsync and vsync inputs are expected to be active high and synchronous to the clock.

Top module: `coast_window_gen`

## Requirements
- R1: While reset is asserted and after it is released, coast is low as long as vsync stays low, and no frame length is known.
- R2: Whenever vsync is high, coast is high.
- R3: Each vsync rising edge clears the line count. Each hsync rising edge in another cycle raises it by one, saturating at its maximum. From the second vsync rising edge onward, each vsync rising edge stores the count it clears as the frame length L.
- R4: Once L is known and the pre-coast setting P is between 1 and L-1, coast rises in the cycle after the line count reaches L-P. It then stays high until vsync rises.
- R5: When L is known and P is L or more, coast stays high over the whole frame.
- R6: A vsync falling edge loads the post-coast setting N. Coast then stays high until N hsync rising edges have followed that edge, and it drops in the cycle after the Nth edge is sampled. With N = 0, coast falls together with vsync.
- R7: With P = 0 and N = 0, coast equals vsync combinationally.
- R8: Before a frame length has been stored, P has no effect on coast.
- R9: The frame length is measured again in every frame. The window in each frame uses the length stored at that frame's vsync rising edge, so a change in frame length affects the pre-coast window one frame later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high, synchronous |
| vsync_i | input | 1 | Vertical sync, active high, synchronous |
| pre_coast_i | input | SET_W | Lines of coast before vsync (P) |
| post_coast_i | input | SET_W | Lines of coast after vsync (N) |
| coast_o | output | 1 | Coast flag to the PLL |

## Verification
The assertions assume that a vsync edge and an hsync rising edge never fall in the same clock cycle. They also assume that both settings stay constant while a post-coast count is running. The stimulus meets both conditions: each line starts with hsync rising, vsync changes only in the middle of a line, and the settings change only while reset is held. Coast is sampled late in each line, after every register update caused by that line's hsync edge has settled. The expected level for line j of a frame is therefore fixed by j, the vsync width, N, P and the previously stored length.

// File: rtl/coast_win_pkg.sv
`timescale 1ns/1ps
package coast_win_pkg;

  // Early window test: open once count has come within pre lines of len.
  // Kept in 32-bit space so no subtraction can wrap.
  function automatic logic pre_window_open(input logic [31:0] cnt,
                                           input logic [31:0] len,
                                           input logic [31:0] pre);
    return (pre != 32'd0) && ((cnt + pre) >= len);
  endfunction

  // Post counter step: one line consumed per hsync edge, floor at zero.
  function automatic logic [31:0] post_step(input logic [31:0] cur);
    return (cur == 32'd0) ? 32'd0 : cur - 32'd1;
  endfunction

endpackage

// File: rtl/cw_edge_detect.sv
`timescale 1ns/1ps
module cw_edge_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] & prev_q[g];
  end

endmodule

// File: rtl/cw_line_tracker.sv
`timescale 1ns/1ps
module cw_line_tracker #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise_i,
  input  logic              vs_rise_i,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic [LINE_W-1:0] frame_len_o,
  output logic              frame_valid_o
);

  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] line_cnt_q;
  logic [LINE_W-1:0] frame_len_q;
  logic              seen_vs_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt_q  <= '0;
      frame_len_q <= '0;
      seen_vs_q   <= 1'b0;
      valid_q     <= 1'b0;
    end else if (vs_rise_i) begin
      line_cnt_q <= '0;
      seen_vs_q  <= 1'b1;
      if (seen_vs_q) begin
        frame_len_q <= line_cnt_q;
        valid_q     <= 1'b1;
      end
    end else if (hs_rise_i && (line_cnt_q != CNT_MAX)) begin
      line_cnt_q <= line_cnt_q + 1'b1;
    end
  end

  assign line_cnt_o    = line_cnt_q;
  assign frame_len_o   = frame_len_q;
  assign frame_valid_o = valid_q;

  a_r3_clear_on_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise_i |=> (line_cnt_q == '0));

  a_r3_count_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise_i && !vs_rise_i && (line_cnt_q != CNT_MAX))
      |=> (line_cnt_q == $past(line_cnt_q) + 1'b1));

  a_r3_latch_length: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise_i && seen_vs_q) |=> (frame_len_q == $past(line_cnt_q)));

  a_r8_valid_needs_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(vs_rise_i));

endmodule

// File: rtl/cw_coast_ctrl.sv
`timescale 1ns/1ps
module cw_coast_ctrl
  import coast_win_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int SET_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              hs_rise_i,
  input  logic              vs_rise_i,
  input  logic              vs_fall_i,
  input  logic [LINE_W-1:0] line_cnt_i,
  input  logic [LINE_W-1:0] frame_len_i,
  input  logic              frame_valid_i,
  input  logic [SET_W-1:0]  pre_coast_i,
  input  logic [SET_W-1:0]  post_coast_i,
  output logic              pre_hit_o,
  output logic              post_active_o,
  output logic              coast_o
);

  logic [SET_W-1:0] post_cnt_q;
  logic [31:0]      post_next;

  assign post_next = post_step(32'(post_cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cnt_q <= '0;
    end else if (vs_rise_i) begin
      post_cnt_q <= '0;
    end else if (vs_fall_i) begin
      post_cnt_q <= post_coast_i;
    end else if (hs_rise_i && !vsync_i) begin
      post_cnt_q <= post_next[SET_W-1:0];
    end
  end

  assign post_active_o = (post_cnt_q != '0);
  assign pre_hit_o     = frame_valid_i &&
                         pre_window_open(32'(line_cnt_i), 32'(frame_len_i),
                                         32'(pre_coast_i));
  assign coast_o       = vsync_i | post_active_o | pre_hit_o;

  a_r2_vsync_covered: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |-> coast_o);

  a_r6_load_post: assert property (@(posedge clk) disable iff (!rst_n)
    vs_fall_i |=> (post_cnt_q == $past(post_coast_i)));

  a_r6_hold_between_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (post_active_o && !hs_rise_i && !vs_rise_i && !vs_fall_i) |=> $stable(post_cnt_q));

  a_r6_step_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    (post_active_o && hs_rise_i && !vsync_i && !vs_fall_i && !vs_rise_i)
      |=> (post_cnt_q == $past(post_cnt_q) - 1'b1));

  a_r8_no_pre_unmeasured: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_valid_i && !vsync_i && !post_active_o) |-> !coast_o);

endmodule

// File: rtl/coast_window_gen.sv
`timescale 1ns/1ps
module coast_window_gen #(
  parameter int LINE_W = 11,
  parameter int SET_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic [SET_W-1:0] pre_coast_i,
  input  logic [SET_W-1:0] post_coast_i,
  output logic             coast_o
);

  localparam int SYNC_N = 2;
  localparam int HS_IDX = 0;
  localparam int VS_IDX = 1;

  logic [SYNC_N-1:0] sync_rise;
  logic [SYNC_N-1:0] sync_fall;
  logic              hs_rise;
  logic              vs_rise;
  logic              vs_fall;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] frame_len;
  logic              frame_valid;
  logic              pre_hit;
  logic              post_active;

  cw_edge_detect #(.N(SYNC_N)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({vsync_i, hsync_i}),
    .rise_o (sync_rise),
    .fall_o (sync_fall)
  );

  assign hs_rise = sync_rise[HS_IDX];
  assign vs_rise = sync_rise[VS_IDX];
  assign vs_fall = sync_fall[VS_IDX];

  cw_line_tracker #(.LINE_W(LINE_W)) u_tracker (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_rise_i     (hs_rise),
    .vs_rise_i     (vs_rise),
    .line_cnt_o    (line_cnt),
    .frame_len_o   (frame_len),
    .frame_valid_o (frame_valid)
  );

  cw_coast_ctrl #(.LINE_W(LINE_W), .SET_W(SET_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .vsync_i       (vsync_i),
    .hs_rise_i     (hs_rise),
    .vs_rise_i     (vs_rise),
    .vs_fall_i     (vs_fall),
    .line_cnt_i    (line_cnt),
    .frame_len_i   (frame_len),
    .frame_valid_i (frame_valid),
    .pre_coast_i   (pre_coast_i),
    .post_coast_i  (post_coast_i),
    .pre_hit_o     (pre_hit),
    .post_active_o (post_active),
    .coast_o       (coast_o)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_valid && !vsync_i && !post_active) |-> !pre_hit);

endmodule

// File: tb/coast_window_gen_bench.sv
`timescale 1ns/1ps
module coast_window_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_CLKS  = 8;

  typedef struct packed {
    int f;  // lines per frame
    int v;  // vsync width in lines
    int p;  // pre-coast
    int n;  // post-coast
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{12, 2,  0, 0},
    '{12, 2,  3, 0},
    '{12, 2,  0, 3},
    '{16, 3,  2, 4},
    '{10, 2, 10, 1},
    '{10, 1, 15, 0},
    '{20, 2,  1, 1},
    '{14, 4,  5, 2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0;
  logic       vsync = 1'b0;
  logic [7:0] pre_set = 8'd0;
  logic [7:0] post_set = 8'd0;
  logic       coast;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coast_window_gen u_coast_window_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync_i      (hsync),
    .vsync_i      (vsync),
    .pre_coast_i  (pre_set),
    .post_coast_i (post_set),
    .coast_o      (coast)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One line: hsync high for two clocks at the start, vsync set mid-line,
  // coast sampled late in the line.
  task automatic run_line(input logic vs_lvl, input logic exp, input string tag, input int j);
    for (int c = 0; c < LINE_CLKS; c++) begin
      @(posedge clk); #1;
      hsync = (c < 2);
      if (c == 4) vsync = vs_lvl;
      if (c == 6) begin
        #2;
        check(coast, exp, tag, $sformatf("line %0d", j));
      end
    end
  endtask

  task automatic run_frame(input int f, input int v, input int p, input int n,
                           input int lprev, input bit valid, input string force_tag);
    for (int j = 0; j < f; j++) begin
      bit    in_vs, in_post, in_pre, exp;
      string tag;
      in_vs   = (j < v);
      in_post = (j < v + n);
      in_pre  = valid && (p > 0) && (j >= lprev - p);
      exp     = in_vs || in_post || in_pre;
      if (force_tag != "")           tag = force_tag;
      else if (p == 0 && n == 0)     tag = "R7";
      else if (in_vs)                tag = "R2";
      else if (in_post)              tag = "R6";
      else if (in_pre)               tag = (p >= lprev) ? "R5" : "R4";
      else if (!valid && p > 0 && j >= f - p) tag = "R8";
      else                           tag = "R3";
      run_line(in_vs, exp, tag, j);
    end
  endtask

  task automatic apply_reset(input int p, input int n);
    rst_n    = 1'b0;
    hsync    = 1'b0;
    vsync    = 1'b0;
    pre_set  = 8'(p);
    post_set = 8'(n);
    repeat (3) @(posedge clk);
    #1;
    check(coast, 1'b0, "R1", "coast during reset");
    rst_n = 1'b1;
    run_line(1'b0, 1'b0, "R1", -1);
    run_line(1'b0, 1'b0, "R1", -1);
  endtask

  initial begin
    for (int k = 0; k < NVEC; k++) begin
      apply_reset(VECS[k].p, VECS[k].n);
      run_frame(VECS[k].f, VECS[k].v, VECS[k].p, VECS[k].n, 0, 1'b0, "");
      run_frame(VECS[k].f, VECS[k].v, VECS[k].p, VECS[k].n, VECS[k].f, 1'b1, "");
      run_frame(VECS[k].f, VECS[k].v, VECS[k].p, VECS[k].n, VECS[k].f, 1'b1, "");
    end

    // R9: frame length changes; window follows the previously stored length.
    apply_reset(2, 1);
    run_frame(12, 2, 2, 1, 0,  1'b0, "R8");
    run_frame(12, 2, 2, 1, 12, 1'b1, "R9");
    run_frame(8,  2, 2, 1, 12, 1'b1, "R9");
    run_frame(8,  2, 2, 1, 8,  1'b1, "R9");
    run_frame(14, 2, 2, 1, 8,  1'b1, "R9");

    // R7: settings at zero, coast tracks vsync mid-line cycle by cycle.
    apply_reset(0, 0);
    run_frame(6, 2, 0, 0, 0, 1'b0, "R7");
    @(posedge clk); #1;
    vsync = 1'b1; #1;
    check(coast, 1'b1, "R7", "same-cycle vsync rise");
    @(posedge clk); #1;
    vsync = 1'b0; #1;
    check(coast, 1'b0, "R7", "same-cycle vsync fall");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule